// File: doc/BRIEF.md
# Load-Store Address Disambiguation Unit

This block decides what a load may do once its effective address is known but older stores are still waiting to retire. The caller presents the load address together with a snapshot of the store queue. The snapshot is a circular table of store entries. Each entry has a valid bit, an address-known bit, a 32-bit address, a data-ready bit and a 32-bit data word. Program age comes from an entry's circular distance from the queue head. The load carries the store-queue tail pointer that was current when it entered the machine, so only the entries between the head and that pointer are older than the load.

The unit compares the load address against every older store at the same time. It gives one of four answers, one cycle after the request. Block means some older store has no address yet, so the load must retry later. Cache means no older store matches, so the load may read memory ahead of the stores. Forward means the youngest matching older store already has its data, and that data is returned. Wait means the youngest matching older store has no data yet, and its entry number is returned as the tag the load should wait on. Stores reach memory only at retirement and in program order, so memory write-after-write and write-after-read ordering is not handled here.

Top module: `ld_disambig_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. When no request was made, `rsp_kind`, `rsp_data` and `rsp_tag` are all zero.
- R2: If any valid older store has its address-known bit low, the result is Block (`rsp_kind` = 2'b00), with data and tag zero. This holds even when another older store matches the load address.
- R3: The older stores are the entries whose circular distance from `head_ptr[2:0]` is less than `ld_tail - head_ptr`. This count is taken modulo 16 on the 4-bit pointers and capped at 8. Entries outside this range take no part in blocking or matching.
- R4: An entry with its valid bit low takes no part in blocking or matching.
- R5: With no block and no matching older store, the result is Cache (`rsp_kind` = 2'b01), with data and tag zero.
- R6: If the selected matching store has data ready, the result is Forward (`rsp_kind` = 2'b10). `rsp_data` is that store's data and `rsp_tag` is its entry index.
- R7: If the selected matching store has no data yet, the result is Wait (`rsp_kind` = 2'b11). `rsp_tag` is that store's entry index and `rsp_data` is zero.
- R8: When several older stores match, the one with the largest circular distance from the head is selected, that is, the youngest one older than the load. This also applies when the older range wraps past entry 7.
- R9: A match needs all 32 address bits to be equal. A store whose address differs in any single bit does not match.
- R10: While reset is held, `rsp_valid`, `rsp_kind`, `rsp_data` and `rsp_tag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present this cycle |
| req_addr | input | 32 | Load effective address |
| head_ptr | input | 4 | Store queue head pointer (index plus wrap bit) |
| ld_tail | input | 4 | Store queue tail pointer captured when the load entered |
| st_valid | input | 8 | Entry holds a pending store |
| st_addr_known | input | 8 | Entry address has been computed |
| st_addr | input | 256 | Entry addresses, entry i at bits [32i+31:32i] |
| st_data_ready | input | 8 | Entry store data is available |
| st_data | input | 256 | Entry data words, entry i at bits [32i+31:32i] |
| rsp_valid | output | 1 | Registered response valid |
| rsp_kind | output | 2 | 00 Block, 01 Cache, 10 Forward, 11 Wait |
| rsp_data | output | 32 | Forwarded data (Forward only) |
| rsp_tag | output | 3 | Selected store entry (Forward and Wait) |

## Verification
Directed tables set up each outcome on its own: a single ready match, a single unready match, several matches where only the youngest should win, and an unknown older address that hides a match. Range patterns put matching or unresolved stores just past the load's tail, on invalid entries, and across the wrap from entry 7 to entry 0. These separate a correct age window from one that ignores age or the wrap. Single-bit address differences at both ends of the word show that the full width is compared. A long stretch of random tables over a small address set follows, each cycle compared with a behavioural model.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  typedef enum logic [1:0] {
    LD_BLOCK = 2'b00,
    LD_CACHE = 2'b01,
    LD_FWD   = 2'b10,
    LD_WAIT  = 2'b11
  } ld_kind_e;
endpackage

// File: rtl/ldq_age_mask.sv
module ldq_age_mask #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    head_ptr,
  input  logic [PW-1:0]    ld_tail,
  output logic [DEPTH-1:0] older,
  output logic [PW-1:0]    older_cnt
);
  // number of stores ahead of the load, capped at the table size
  function automatic logic [PW-1:0] older_count(logic [PW-1:0] h, logic [PW-1:0] t);
    logic [PW-1:0] d;
    d = t - h;
    if (d > PW'(DEPTH)) d = PW'(DEPTH);
    return d;
  endfunction

  // circular distance of an entry from the head
  function automatic logic [IW-1:0] rel_dist(logic [IW-1:0] idx, logic [IW-1:0] h);
    return idx - h;
  endfunction

  assign older_cnt = older_count(head_ptr, ld_tail);

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    assign older[i] = {1'b0, rel_dist(IW'(i), head_ptr[IW-1:0])} < older_cnt;
  end

  // R3: mask population equals the computed older count
  assert_older_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(older) == int'(older_cnt));
endmodule

// File: rtl/ldq_addr_cmp.sv
module ldq_addr_cmp #(
  parameter int DEPTH = 8,
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       req_addr,
  input  logic [DEPTH*AW-1:0] st_addr,
  input  logic [DEPTH-1:0]    st_valid,
  input  logic [DEPTH-1:0]    st_addr_known,
  input  logic [DEPTH-1:0]    older,
  output logic [DEPTH-1:0]    hit_mask,
  output logic [DEPTH-1:0]    unres_mask
);
  logic [DEPTH-1:0] live;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign live[i]       = st_valid[i] & older[i];
    assign unres_mask[i] = live[i] & ~st_addr_known[i];
    assign hit_mask[i]   = live[i] & st_addr_known[i] &
                           (st_addr[i*AW +: AW] == req_addr);
  end

  // R2: an entry is never both unresolved and matching
  assert_hit_excl_unres_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mask & unres_mask) == '0);
  // R3: hits only among entries the age mask marks older
  assert_hit_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mask & ~older) == '0);
  // R4: invalid entries neither hit nor block
  assert_invalid_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_mask | unres_mask) & ~st_valid) == '0);
endmodule

// File: rtl/ldq_young_pick.sv
module ldq_young_pick #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] hit_mask,
  input  logic [IW-1:0]    head_idx,
  output logic             sel_hit,
  output logic [IW-1:0]    sel_idx
);
  // walk from oldest to youngest; the last hit seen is the youngest
  always_comb begin
    logic [IW-1:0] cand;
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int unsigned r = 0; r < DEPTH; r++) begin
      cand = head_idx + IW'(r);
      if (hit_mask[cand]) begin
        sel_hit = 1'b1;
        sel_idx = cand;
      end
    end
  end

  // R8: the chosen entry is a real hit
  assert_pick_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> hit_mask[sel_idx]);
  // R5: no selection only when nothing matched
  assert_nopick_nohit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |-> (hit_mask == '0));
endmodule

// File: rtl/ld_disambig_unit.sv
module ld_disambig_unit #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_addr,
  input  logic [PW-1:0]       head_ptr,
  input  logic [PW-1:0]       ld_tail,
  input  logic [DEPTH-1:0]    st_valid,
  input  logic [DEPTH-1:0]    st_addr_known,
  input  logic [DEPTH*AW-1:0] st_addr,
  input  logic [DEPTH-1:0]    st_data_ready,
  input  logic [DEPTH*DW-1:0] st_data,
  output logic                rsp_valid,
  output logic [1:0]          rsp_kind,
  output logic [DW-1:0]       rsp_data,
  output logic [IW-1:0]       rsp_tag
);
  import ldq_pkg::*;

  logic [DEPTH-1:0] older;
  logic [PW-1:0]    older_cnt;
  logic [DEPTH-1:0] hit_mask;
  logic [DEPTH-1:0] unres_mask;
  logic             sel_hit;
  logic [IW-1:0]    sel_idx;
  logic             any_unres;
  ld_kind_e         nxt_kind;
  logic [DW-1:0]    nxt_data;
  logic [IW-1:0]    nxt_tag;

  ldq_age_mask #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr), .ld_tail(ld_tail),
    .older(older), .older_cnt(older_cnt)
  );

  ldq_addr_cmp #(.DEPTH(DEPTH), .AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .st_addr(st_addr),
    .st_valid(st_valid), .st_addr_known(st_addr_known), .older(older),
    .hit_mask(hit_mask), .unres_mask(unres_mask)
  );

  ldq_young_pick #(.DEPTH(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n), .hit_mask(hit_mask),
    .head_idx(head_ptr[IW-1:0]), .sel_hit(sel_hit), .sel_idx(sel_idx)
  );

  assign any_unres = |unres_mask;

  always_comb begin
    nxt_kind = LD_CACHE;
    nxt_data = '0;
    nxt_tag  = '0;
    if (any_unres) begin
      nxt_kind = LD_BLOCK;
    end else if (sel_hit) begin
      nxt_tag = sel_idx;
      if (st_data_ready[sel_idx]) begin
        nxt_kind = LD_FWD;
        nxt_data = st_data[sel_idx*DW +: DW];
      end else begin
        nxt_kind = LD_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= 2'b00;
      rsp_data  <= '0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= req_valid ? 2'(nxt_kind) : 2'b00;
      rsp_data  <= req_valid ? nxt_data : '0;
      rsp_tag   <= req_valid ? nxt_tag : '0;
    end
  end

  // R1: one response per request, one cycle later
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2: unresolved older store forces block
  assert_block_on_unknown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any_unres) |=> (rsp_kind == 2'(LD_BLOCK)));
  // R3: selected store lies inside the older window
  assert_pick_is_older_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> older[sel_idx]);
  // R5: clean window without match goes to cache
  assert_cache_no_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_unres && hit_mask == '0) |=> (rsp_kind == 2'(LD_CACHE)));
  // R6: forwarding only from a ready store, reporting its index
  assert_fwd_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'(LD_FWD)) |->
      ($past(st_data_ready[sel_idx]) && rsp_tag == $past(sel_idx)));
  // R7: waiting carries no data
  assert_wait_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'(LD_WAIT)) |-> (rsp_data == '0));
endmodule

// File: tb/ld_disambig_unit_test.sv
module ld_disambig_unit_test;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [3:0]    head_ptr = '0;
  logic [3:0]    ld_tail = '0;
  logic [N-1:0]  st_valid = '0;
  logic [N-1:0]  st_addr_known = '0;
  logic [N*32-1:0] st_addr = '0;
  logic [N-1:0]  st_data_ready = '0;
  logic [N*32-1:0] st_data = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_kind;
  logic [31:0]   rsp_data;
  logic [2:0]    rsp_tag;

  // bench-side table
  bit          b_valid[N];
  bit          b_known[N];
  bit          b_ready[N];
  logic [31:0] b_addr[N];
  logic [31:0] b_data[N];
  bit          b_req;
  logic [31:0] b_ld;
  int          b_head;
  int          b_tail;

  // expectation for the next sample
  bit          have_exp = 0;
  logic        e_valid;
  logic [1:0]  e_kind;
  logic [31:0] e_data;
  logic [2:0]  e_tag;
  string       e_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ld_disambig_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .head_ptr(head_ptr), .ld_tail(ld_tail), .st_valid(st_valid),
    .st_addr_known(st_addr_known), .st_addr(st_addr),
    .st_data_ready(st_data_ready), .st_data(st_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  always #5 clk = ~clk;

  task automatic check_out(string req, logic v, logic [1:0] k, logic [31:0] d, logic [2:0] t);
    checks++;
    if (rsp_valid !== v || rsp_kind !== k || rsp_data !== d || rsp_tag !== t) begin
      errors++;
      $display("FAIL %s: got v=%0b k=%0d d=%h t=%0d expected v=%0b k=%0d d=%h t=%0d",
               req, rsp_valid, rsp_kind, rsp_data, rsp_tag, v, k, d, t);
    end
  endtask

  // behavioural model: walk older stores oldest first
  task automatic model(string tag);
    int cnt;
    bit blk;
    int best;
    cnt = (b_tail - b_head) & 15;
    if (cnt > N) cnt = N;
    blk = 0;
    best = -1;
    for (int r = 0; r < cnt; r++) begin
      int i;
      i = (b_head + r) % N;
      if (b_valid[i]) begin
        if (!b_known[i]) blk = 1;
        else if (b_addr[i] == b_ld) best = i;
      end
    end
    e_valid = b_req;
    e_kind = 2'b00; e_data = '0; e_tag = '0;
    if (!b_req) e_req = "R1";
    else if (blk) begin e_kind = 2'b00; e_req = "R2"; end
    else if (best < 0) begin e_kind = 2'b01; e_req = "R5"; end
    else if (b_ready[best]) begin
      e_kind = 2'b10; e_data = b_data[best]; e_tag = 3'(best); e_req = "R6";
    end else begin
      e_kind = 2'b11; e_tag = 3'(best); e_req = "R7";
    end
    if (tag != "") e_req = tag;
  endtask

  // compare the pending expectation, then drive the bench table
  task automatic step(string tag);
    @(negedge clk);
    if (have_exp) check_out(e_req, e_valid, e_kind, e_data, e_tag);
    req_valid = b_req;
    req_addr  = b_ld;
    head_ptr  = 4'(b_head);
    ld_tail   = 4'(b_tail);
    for (int i = 0; i < N; i++) begin
      st_valid[i] = b_valid[i];
      st_addr_known[i] = b_known[i];
      st_data_ready[i] = b_ready[i];
      st_addr[i*32 +: 32] = b_addr[i];
      st_data[i*32 +: 32] = b_data[i];
    end
    model(tag);
    have_exp = 1;
  endtask

  task automatic clear_table();
    for (int i = 0; i < N; i++) begin
      b_valid[i] = 0; b_known[i] = 0; b_ready[i] = 0;
      b_addr[i] = 32'h1000_0000 + 32'(i * 16);
      b_data[i] = 32'hD000_0000 + 32'(i);
    end
  endtask

  task automatic set_st(int i, logic [31:0] a, bit k, bit rdy);
    b_valid[i] = 1; b_known[i] = k; b_ready[i] = rdy; b_addr[i] = a;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end expected end of run");
    finish_run();
  end

  initial begin
    logic [31:0] A;
    A = 32'h0000_4A40;
    clear_table();
    b_req = 0; b_ld = A; b_head = 0; b_tail = 0;
    // R10: outputs held at zero in reset
    repeat (3) @(negedge clk);
    check_out("R10", 1'b0, 2'b00, 32'h0, 3'd0);
    @(negedge clk);
    check_out("R10", 1'b0, 2'b00, 32'h0, 3'd0);
    rst_n = 1'b1;

    // R1: idle gives no response
    step("R1");
    // R5: empty queue, go to cache
    b_req = 1; step("R5");
    // R6: single ready match at entry 2
    b_tail = 4;
    set_st(0, 32'h10, 1, 1); set_st(1, 32'h20, 1, 1);
    set_st(2, A, 1, 1); set_st(3, 32'h30, 1, 0);
    step("R6");
    // R7: same match, data missing
    b_ready[2] = 0; step("R7");
    // R8: older ready match at 1 loses to younger unready at 2
    b_addr[1] = A; step("R8");
    // R8: youngest at 3 ready now wins
    b_addr[3] = A; b_ready[3] = 1; step("R8");
    // R2: unknown older address hides matches
    b_known[0] = 0; step("R2");
    b_known[0] = 1;
    // R3: matches beyond the load tail are ignored
    clear_table();
    set_st(0, 32'h10, 1, 1); set_st(1, 32'h20, 1, 1);
    set_st(2, A, 1, 1); set_st(3, 32'h0, 0, 0);
    b_tail = 2; step("R3");
    // R3: younger unknown store does not block, older match still found
    b_addr[1] = A; step("R3");
    // R4: invalid entries with matching or unknown address are ignored
    clear_table();
    b_addr[0] = A; b_known[0] = 1; b_ready[0] = 1;
    b_known[1] = 0;
    b_tail = 2; step("R4");
    // R8: wrap window 6,7,0,1 with matches at 7 and 1
    clear_table();
    b_head = 6; b_tail = 10;
    set_st(6, 32'h60, 1, 1); set_st(7, A, 1, 1);
    set_st(0, 32'h70, 1, 1); set_st(1, A, 1, 1);
    step("R8");
    // R8: matches at 6 and 7 only, 7 wins
    b_addr[1] = 32'h90; b_addr[6] = A; step("R8");
    // R3: head in upper half with wrap bit, full table of 8 older
    clear_table();
    b_head = 11; b_tail = 19 & 15;
    for (int i = 0; i < N; i++) set_st(i, 32'h100 + 32'(i), 1, 1);
    b_addr[2] = A; b_addr[4] = A; step("R3");
    // R9: single-bit differences do not match
    clear_table();
    b_head = 0; b_tail = 3;
    set_st(0, A ^ 32'h8000_0000, 1, 1); set_st(1, A ^ 32'h1, 1, 1);
    set_st(2, A ^ 32'h0001_0000, 1, 0);
    step("R9");
    // R1: gap then back-to-back requests
    b_req = 0; step("R1");
    b_req = 1; b_addr[1] = A; step("R6");
    step("R6");

    // random tables over a small address set
    for (int n = 0; n < 600; n++) begin
      b_req = ($urandom_range(0, 9) != 0);
      b_ld = 32'h40 + 32'($urandom_range(0, 3));
      b_head = $urandom_range(0, 15);
      b_tail = (b_head + $urandom_range(0, 8)) & 15;
      for (int i = 0; i < N; i++) begin
        b_valid[i] = ($urandom_range(0, 4) != 0);
        b_known[i] = ($urandom_range(0, 7) != 0);
        b_ready[i] = $urandom_range(0, 1);
        b_addr[i] = 32'h40 + 32'($urandom_range(0, 3));
        b_data[i] = $urandom;
      end
      step("");
    end
    b_req = 0;
    step("R1");
    step("R1");
    finish_run();
  end
endmodule